// File: doc/BRIEF.md
# Periodic Timer Comparator Unit

This block is a memory-mapped event timer. It holds one free-running 64-bit up-counter and one comparator channel. The channel raises an interrupt when the counter reaches a programmed match value. In one-shot mode the channel fires once. In periodic mode it advances its match value by a fixed period on every hit, so the timer keeps a steady tick with no software help after setup.

Software reaches the block over a simple 32-bit register bus. Writes take effect on the clock edge where `wr_en` is high. Read data is combinational while `rd_en` is high and is zero otherwise.

Byte offsets:
- 0x00: global control. Bit 0 is the run bit.
- 0x04: interrupt status. Bit 0 is write-one-to-clear.
- 0x08: counter low half.
- 0x0C: counter high half.
- 0x10: channel setup.
- 0x14: comparator low half.
- 0x18: comparator high half.

A comparator read returns the current match value.

The channel is controlled by a state machine with four states:
- CH_IDLE: the channel is disabled.
- CH_ONCE: one-shot mode, waiting for the match.
- CH_SPENT: one-shot mode after it has fired.
- CH_REPEAT: periodic mode.

Transitions:
- Any state goes to CH_IDLE when the enable bit is cleared.
- CH_IDLE goes to CH_REPEAT or CH_ONCE when the channel is enabled, depending on the periodic bit.
- CH_ONCE goes to CH_SPENT on a hit.
- CH_SPENT goes back to CH_ONCE when a new match value is loaded.
- CH_REPEAT goes to CH_ONCE when the periodic bit is cleared.
- CH_ONCE and CH_SPENT go to CH_REPEAT when the periodic bit is set.

Top module: `evt_timer_unit`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped, the channel is disabled and `irq` is low.
- R2: While the run bit (offset 0x00, bit 0) is 1, the counter rises by exactly one per clock, and reads of either half return the live value.
- R3: Clearing the run bit freezes the counter; setting it again resumes counting from the held value.
- R4: While stopped, writes to 0x08 and 0x0C load the counter's low and high 32 bits; while running, those writes are ignored.
- R5: The setup register (0x10) holds: bit 0 level-triggered, bit 1 channel enable, bit 2 periodic, bit 3 set-value arm, bit 4 32-bit mode; it reads back as written apart from the arm clearing.
- R6: A write to 0x14 or 0x18 while the arm bit is 1 loads that half of the match value; a write to 0x14 with arm set also clears arm in the same edge.
- R7: A comparator write while arm is 0 loads that half of the period register instead of the match value.
- R8: On each hit in periodic mode the match value becomes the old match value plus the period.
- R9: With the level bit 0, `irq` is a one-cycle pulse in the cycle after each hit.
- R10: With the level bit 1, `irq` follows status bit 0, which is set by a hit and stays set until a 1 is written to bit 0 of 0x04; writing 0 has no effect.
- R11: In one-shot mode the channel fires once at the match value and does not change the match value.
- R12: In 32-bit mode the channel compares only the low 32 counter bits, and its periodic reload wraps modulo 2^32 with the match high half held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data (zero when `rd_en` is low) |
| irq | output | 1 | Channel interrupt, edge or level |

## Verification
The hardest case to reach from the ports is the 32-bit mode wrap. It needs a low-half match in the same run where the low half of the counter rolls over. The stimulus stops the counter and loads it just below 2^32 with a nonzero high half, so a full 64-bit compare could never match. It then arms a match a few counts ahead and sets a period that carries the next match past zero. The test then checks that the second interrupt lands on the wrapped low value, and that the comparator reads back a match with a zero high half while the counter's high half has carried.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_SETUP  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h18;

    localparam int SETUP_W = 5;

    typedef struct packed {
        logic wide_off;   // bit 4: 32-bit mode
        logic arm;        // bit 3: next comparator write loads match
        logic repeat_on;  // bit 2: periodic
        logic enable;     // bit 1: channel enable
        logic level;      // bit 0: level-triggered interrupt
    } setup_t;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ONCE   = 2'd1,
        CH_SPENT  = 2'd2,
        CH_REPEAT = 2'd3
    } ch_state_t;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                load_lo,
    input  logic                load_hi,
    input  logic [HALF_W-1:0]   load_val,
    output logic [2*HALF_W-1:0] value
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + {{(FULL_W-1){1'b0}}, 1'b1};
        end else if (load_lo) begin
            cnt_q[HALF_W-1:0] <= load_val;
        end else if (load_hi) begin
            cnt_q[FULL_W-1:HALF_W] <= load_val;
        end
    end

    assign value = cnt_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                setup_wr,
    input  logic                cmp_lo_wr,
    input  logic                cmp_hi_wr,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                stat_clr,
    input  logic                cnt_run,
    input  logic [2*HALF_W-1:0] count,
    output setup_t              setup_q,
    output logic [2*HALF_W-1:0] match_q,
    output logic                status_q,
    output logic                irq
);
    localparam int FULL_W = 2 * HALF_W;

    ch_state_t         state_q, state_d;
    logic [FULL_W-1:0] period_q;
    logic              pulse_q;
    logic              hit;
    logic              equal;
    logic              match_load;
    logic              waiting;

    assign match_load = (cmp_lo_wr | cmp_hi_wr) & setup_q.arm;
    assign equal   = setup_q.wide_off ? (count[HALF_W-1:0] == match_q[HALF_W-1:0])
                                      : (count == match_q);
    assign waiting = (state_q == CH_ONCE) || (state_q == CH_REPEAT);
    assign hit     = waiting && cnt_run && equal;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (setup_q.enable) begin
                    state_d = setup_q.repeat_on ? CH_REPEAT : CH_ONCE;
                end
            end
            CH_ONCE: begin
                if (!setup_q.enable)        state_d = CH_IDLE;
                else if (setup_q.repeat_on) state_d = CH_REPEAT;
                else if (hit)               state_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (!setup_q.enable)        state_d = CH_IDLE;
                else if (setup_q.repeat_on) state_d = CH_REPEAT;
                else if (match_load)        state_d = CH_ONCE;
            end
            CH_REPEAT: begin
                if (!setup_q.enable)         state_d = CH_IDLE;
                else if (!setup_q.repeat_on) state_d = CH_ONCE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs and channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q  <= '0;
            match_q  <= '0;
            period_q <= '0;
            pulse_q  <= 1'b0;
            status_q <= 1'b0;
        end else begin
            pulse_q  <= hit;
            status_q <= hit | (status_q & ~stat_clr);

            if (setup_wr) begin
                setup_q <= setup_t'(wdata[SETUP_W-1:0]);
            end else if (cmp_lo_wr && setup_q.arm) begin
                setup_q.arm <= 1'b0;
            end

            if (cmp_lo_wr) begin
                if (setup_q.arm) match_q[HALF_W-1:0]  <= wdata;
                else             period_q[HALF_W-1:0] <= wdata;
            end else if (cmp_hi_wr) begin
                if (setup_q.arm) match_q[FULL_W-1:HALF_W]  <= wdata;
                else             period_q[FULL_W-1:HALF_W] <= wdata;
            end else if (hit && state_q == CH_REPEAT) begin
                if (setup_q.wide_off) begin
                    match_q <= {{HALF_W{1'b0}},
                                match_q[HALF_W-1:0] + period_q[HALF_W-1:0]};
                end else begin
                    match_q <= match_q + period_q;
                end
            end
        end
    end

    assign irq = setup_q.level ? status_q : pulse_q;

endmodule

// File: rtl/evt_timer_unit.sv
module evt_timer_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int FULL_W = 2 * DATA_W;

    logic              run_q;
    logic [FULL_W-1:0] cnt_val;
    setup_t            setup_q;
    logic [FULL_W-1:0] match_val;
    logic              status_q;

    logic wr_ctrl, wr_stat, wr_cnt_lo, wr_cnt_hi, wr_setup, wr_cmp_lo, wr_cmp_hi;
    logic stat_clr;

    assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
    assign wr_stat   = wr_en && (addr == OFS_STAT);
    assign wr_cnt_lo = wr_en && (addr == OFS_CNT_LO);
    assign wr_cnt_hi = wr_en && (addr == OFS_CNT_HI);
    assign wr_setup  = wr_en && (addr == OFS_SETUP);
    assign wr_cmp_lo = wr_en && (addr == OFS_CMP_LO);
    assign wr_cmp_hi = wr_en && (addr == OFS_CMP_HI);
    assign stat_clr  = wr_stat && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q <= wr_data[0];
        end
    end

    tmr_counter #(.HALF_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .load_lo  (wr_cnt_lo),
        .load_hi  (wr_cnt_hi),
        .load_val (wr_data),
        .value    (cnt_val)
    );

    tmr_channel #(.HALF_W(DATA_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_wr  (wr_setup),
        .cmp_lo_wr (wr_cmp_lo),
        .cmp_hi_wr (wr_cmp_hi),
        .wdata     (wr_data),
        .stat_clr  (stat_clr),
        .cnt_run   (run_q),
        .count     (cnt_val),
        .setup_q   (setup_q),
        .match_q   (match_val),
        .status_q  (status_q),
        .irq       (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (addr)
                OFS_CTRL:   rd_data = {{(DATA_W-1){1'b0}}, run_q};
                OFS_STAT:   rd_data = {{(DATA_W-1){1'b0}}, status_q};
                OFS_CNT_LO: rd_data = cnt_val[DATA_W-1:0];
                OFS_CNT_HI: rd_data = cnt_val[FULL_W-1:DATA_W];
                OFS_SETUP:  rd_data = {{(DATA_W-SETUP_W){1'b0}}, setup_q};
                OFS_CMP_LO: rd_data = match_val[DATA_W-1:0];
                OFS_CMP_HI: rd_data = match_val[FULL_W-1:DATA_W];
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int FULL_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              cnt_wr,
    input logic [FULL_W-1:0] count,
    input logic              cmp_lo_wr,
    input logic              cmp_wr,
    input logic              arm,
    input logic              hit,
    input logic              repeat_on,
    input logic              wide_off,
    input logic [1:0]        state,
    input logic [FULL_W-1:0] match,
    input logic [FULL_W-1:0] period,
    input logic              level,
    input logic              status,
    input logic              stat_clr,
    input logic              irq
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> count == $past(count) + 1);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> count == $past(count));

    // R6
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo_wr && arm) |=> !arm);

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && state == 2'd3 && !wide_off && !cmp_wr) |=>
            match == $past(match) + $past(period));

    // R9
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !level) |-> $past(hit));

    // R10
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !stat_clr) |=> status);
endmodule

bind evt_timer_unit tmr_chk #(.FULL_W(64)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .cnt_wr    (wr_cnt_lo | wr_cnt_hi),
    .count     (cnt_val),
    .cmp_lo_wr (wr_cmp_lo),
    .cmp_wr    (wr_cmp_lo | wr_cmp_hi),
    .arm       (setup_q.arm),
    .hit       (u_ch.hit),
    .repeat_on (setup_q.repeat_on),
    .wide_off  (setup_q.wide_off),
    .state     (u_ch.state_q),
    .match     (match_val),
    .period    (u_ch.period_q),
    .level     (setup_q.level),
    .status    (status_q),
    .stat_clr  (stat_clr),
    .irq       (irq)
);

// File: tb/evt_timer_unit_tb.sv
module evt_timer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    evt_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        #2;
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check("scoreboard", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // each bus task starts on a falling edge and returns on the next one
    task automatic op_wr(logic [4:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic op_rd(logic [4:0] a, logic [31:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic irq_now(logic e, string tag);
        #2;
        check(tag, {31'b0, irq}, {31'b0, e});
        @(negedge clk);
    endtask

    // samples irq on n falling edges; high only at offsets ta, tb, tc
    task automatic watch(int n, int ta, int tb, int tc, string tag);
        for (int t = 1; t <= n; t++) begin
            irq_now((t == ta) || (t == tb) || (t == tc), tag);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        op_rd(5'h00, 32'd0, "R1 ctrl");
        op_rd(5'h08, 32'd0, "R1 cnt_lo");
        op_rd(5'h0C, 32'd0, "R1 cnt_hi");
        op_rd(5'h10, 32'd0, "R1 setup");
        op_rd(5'h14, 32'd0, "R1 cmp_lo");
        op_rd(5'h04, 32'd0, "R1 stat");

        // R4 load while stopped
        op_wr(5'h08, 32'h100);
        op_wr(5'h0C, 32'h2);
        op_rd(5'h08, 32'h100, "R4 cnt_lo load");
        op_rd(5'h0C, 32'h2, "R4 cnt_hi load");

        // R2 live counting
        op_wr(5'h00, 32'h1);
        op_rd(5'h08, 32'h100, "R2 count first");
        op_rd(5'h08, 32'h101, "R2 count +1");
        op_rd(5'h08, 32'h102, "R2 count +2");
        op_wr(5'h08, 32'hDEAD);
        op_rd(5'h08, 32'h104, "R4 write ignored while running");

        // R3 freeze and resume
        op_wr(5'h00, 32'h0);
        op_rd(5'h08, 32'h106, "R3 frozen");
        idle(5);
        op_rd(5'h08, 32'h106, "R3 still frozen");
        op_wr(5'h00, 32'h1);
        op_wr(5'h00, 32'h0);
        op_rd(5'h08, 32'h107, "R3 resumed from held");
        op_rd(5'h0C, 32'h2, "R3 high half held");

        // R5 R6 R7 R8 R9 periodic edge mode
        op_wr(5'h08, 32'h0);
        op_wr(5'h0C, 32'h0);
        op_wr(5'h10, 32'h0E);
        op_rd(5'h10, 32'h0E, "R5 setup readback");
        op_wr(5'h14, 32'd20);
        op_rd(5'h10, 32'h06, "R6 arm self-cleared");
        op_wr(5'h18, 32'h0);
        op_wr(5'h14, 32'd10);
        op_rd(5'h14, 32'd20, "R7 period write left match");
        op_wr(5'h00, 32'h1);
        watch(45, 22, 32, 42, "R9 edge pulse");
        op_wr(5'h00, 32'h0);
        op_rd(5'h14, 32'd50, "R8 match advanced by period");
        op_rd(5'h18, 32'd0, "R8 match high");
        op_rd(5'h04, 32'h1, "R10 status set by hit");
        op_wr(5'h04, 32'h1);
        op_rd(5'h04, 32'h0, "R10 status cleared");

        // R11 one-shot
        op_wr(5'h10, 32'h0A);
        op_wr(5'h18, 32'h0);
        op_wr(5'h14, 32'd55);
        op_wr(5'h00, 32'h1);
        watch(30, 11, -1, -1, "R11 single fire");
        op_wr(5'h00, 32'h0);
        op_rd(5'h14, 32'd55, "R11 no reload");
        op_rd(5'h08, 32'd77, "R11 counter");

        // R10 level mode
        op_wr(5'h04, 32'h1);
        op_wr(5'h08, 32'h0);
        op_wr(5'h10, 32'h0F);
        op_wr(5'h18, 32'h0);
        op_wr(5'h14, 32'd5);
        op_wr(5'h14, 32'd100);
        op_wr(5'h00, 32'h1);
        idle(10);
        irq_now(1'b1, "R10 level asserted");
        op_wr(5'h00, 32'h0);
        idle(3);
        irq_now(1'b1, "R10 level held");
        op_wr(5'h04, 32'h0);
        irq_now(1'b1, "R10 zero write no effect");
        op_wr(5'h04, 32'h1);
        #2;
        check("R10 cleared by W1C", {31'b0, irq}, 32'd0);
        @(negedge clk);
        op_rd(5'h14, 32'd105, "R8 level-mode reload");

        // R12 32-bit mode with low-half wrap
        op_wr(5'h0C, 32'h1);
        op_wr(5'h08, 32'hFFFF_FFF0);
        op_wr(5'h10, 32'h1E);
        op_wr(5'h14, 32'hFFFF_FFF8);
        op_wr(5'h14, 32'h10);
        op_wr(5'h00, 32'h1);
        watch(30, 10, 26, -1, "R12 low-half match");
        op_wr(5'h00, 32'h0);
        op_rd(5'h08, 32'h0000_000F, "R12 counter low");
        op_rd(5'h0C, 32'h2, "R12 counter high carried");
        op_rd(5'h14, 32'h18, "R12 match wrapped");
        op_rd(5'h18, 32'h0, "R12 match high zero");

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule